// File: doc/BRIEF.md
# Qualified Input Transition Detector

This block decides when one step of a power sequence may be treated as complete. A select field picks one line from a vector of asynchronous status inputs. An invert control sets whether the block waits for a high level or a low level on that line. Once armed, the block reports completion only after the chosen line has stayed at that level for a programmable dwell, counted in microsecond ticks. A short excursion away from the level throws away all the dwell built up so far, so glitches and bounce are rejected rather than taken as an edge.

The sequencer that owns the block pulses `arm` when it enters a state and then waits for `step_done`. Choosing the next state is left to the sequencer. While armed and not yet complete, `timing` is high. After completion the block stays quiet until it is armed again.

Top module: `qual_step_detector`

## Requirements
- R1: After reset, `step_done` and `timing` are both 0.
- R2: A cycle with `arm` high clears the dwell and any earlier completion. `timing` is 1 in the next cycle, and `step_done` is 0 in that cycle.
- R3: The watched line is bit `sel` of `in_vec` (bit index equal to the value of `sel`). Activity on the other bits does not affect `step_done` or `timing`.
- R4: With `invert` = 0 the target level is 1. With `invert` = 1 the target level is 0.
- R5: Each input line passes through two flip-flops before it is compared. With a dwell value D > 0, a line that reaches its target level while the block is armed makes `step_done` pulse after the target level has been seen for D × TICK_DIV consecutive clock cycles. If the input is changed just after the edge that ends clock cycle c, the pulse is visible in cycle c + 2 + D × TICK_DIV.
- R6: If the synchronized line leaves the target level for even one cycle during the dwell, the dwell restarts from zero when the line returns.
- R7: With a dwell of 0, `step_done` pulses in the cycle after the first cycle in which the synchronized line is at its target level while armed. If the line is already at the target when `arm` is pulsed in cycle c, the pulse comes in cycle c + 2.
- R8: `step_done` is a single-cycle pulse and fires at most once per arm. `timing` falls in the same cycle that `step_done` rises.
- R9: Pulsing `arm` again, either while waiting or after completion, restarts the qualification from zero. A line already at target when armed in cycle c with dwell D > 0 completes in cycle c + 1 + D × TICK_DIV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vec | input | N_IN | Asynchronous status lines to choose from |
| sel | input | SEL_W | Index of the watched line |
| invert | input | 1 | 0: wait for high, 1: wait for low |
| delay | input | DLY_W | Dwell in microsecond ticks (0 means complete at once) |
| arm | input | 1 | One-cycle pulse that starts a new qualification |
| step_done | output | 1 | One-cycle completion pulse |
| timing | output | 1 | High while armed and not yet complete |

## Verification
The hardest case to reach is a dwell that is almost complete when it is cut off. Here the line has already run up most of the required ticks, drops for exactly one synchronized cycle, and comes back. The bench raises the watched line, removes it for one clock a few cycles later, and restores it. It then expects the pulse at a cycle measured only from the second rise, so a design that keeps part of the dwell or leaves the prescaler phase uncleared fires at the wrong cycle. A re-arm issued midway through a dwell is handled the same way: the expected cycle is counted from the second arm, and the monitor flags any pulse at the first arm's deadline as unexpected.

// File: rtl/qsd_pkg.sv
package qsd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WATCH = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

endpackage

// File: rtl/qsd_sync.sv
module qsd_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.stg[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            r_d.stg[i] = r_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign d_out = r_q.stg[STAGES-1];

endmodule

// File: rtl/qsd_tick.sv
module qsd_tick #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_t;

    tick_t r_d, r_q;

    assign tick = run && (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (!run || tick) r_d.cnt = '0;
        else              r_d.cnt = r_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/qsd_dwell.sv
module qsd_dwell
    import qsd_pkg::*;
#(
    parameter int DLY_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             hit,
    input  logic             tick,
    input  logic [DLY_W-1:0] delay,
    output logic             run,
    output logic             done,
    output logic             busy
);

    typedef struct packed {
        phase_e           phase;
        logic [DLY_W-1:0] cnt;
        logic             done;
    } dwell_t;

    dwell_t r_d, r_q;

    logic watching;
    logic last_tick;

    assign watching  = (r_q.phase == PH_WATCH);
    assign last_tick = (r_q.cnt == delay - DLY_W'(1));
    assign run       = watching && hit && !arm;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (arm) begin
            r_d.phase = PH_WATCH;
            r_d.cnt   = '0;
        end else if (watching) begin
            if (!hit) begin
                r_d.cnt = '0;
            end else if (delay == '0) begin
                r_d.done  = 1'b1;
                r_d.phase = PH_DONE;
            end else if (tick) begin
                if (last_tick) begin
                    r_d.done  = 1'b1;
                    r_d.phase = PH_DONE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + DLY_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase <= PH_IDLE;
            r_q.cnt   <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done = r_q.done;
    assign busy = watching;

endmodule

// File: rtl/qual_step_detector.sv
module qual_step_detector #(
    parameter int N_IN     = 8,
    parameter int SEL_W    = $clog2(N_IN),
    parameter int DLY_W    = 19,
    parameter int TICK_DIV = 250,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_vec,
    input  logic [SEL_W-1:0] sel,
    input  logic             invert,
    input  logic [DLY_W-1:0] delay,
    input  logic             arm,
    output logic             step_done,
    output logic             timing
);

    localparam logic [SEL_W:0] SEL_LIM = (SEL_W + 1)'(N_IN);

    logic [N_IN-1:0] in_sync;
    logic            sel_bit;
    logic            hit;
    logic            run;
    logic            tick;

    qsd_sync #(
        .W      (N_IN),
        .STAGES (SYNC_N)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (in_vec),
        .d_out (in_sync)
    );

    always_comb begin
        if ({1'b0, sel} < SEL_LIM) sel_bit = in_sync[sel];
        else                       sel_bit = 1'b0;
    end

    assign hit = sel_bit ^ invert;

    qsd_tick #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    qsd_dwell #(
        .DLY_W (DLY_W)
    ) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .hit   (hit),
        .tick  (tick),
        .delay (delay),
        .run   (run),
        .done  (step_done),
        .busy  (timing)
    );

endmodule

// File: rtl/qsd_checker.sv
module qsd_checker #(
    parameter int DLY_W    = 19,
    parameter int TICK_DIV = 250
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             hit,
    input logic [DLY_W-1:0] delay,
    input logic             step_done,
    input logic             timing
);

    logic [31:0] streak_q;
    logic [31:0] need;

    assign need = 32'(delay) * 32'(TICK_DIV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     streak_q <= '0;
        else if (arm || !timing || !hit) streak_q <= '0;
        else                            streak_q <= streak_q + 32'd1;
    end

    AST_ARM_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (timing && !step_done));                                // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);                                      // R8
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> !timing);                                         // R8
    AST_DONE_FROM_WATCH: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> $past(timing));                                   // R8
    AST_DWELL_MET: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> (streak_q >= need));                              // R5

endmodule

bind qual_step_detector qsd_checker #(
    .DLY_W    (DLY_W),
    .TICK_DIV (TICK_DIV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .hit       (hit),
    .delay     (delay),
    .step_done (step_done),
    .timing    (timing)
);

// File: tb/tb_qual_step_detector.sv
module tb_qual_step_detector;

    localparam int N_IN  = 8;
    localparam int SEL_W = 3;
    localparam int DLY_W = 19;
    localparam int DIV   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_IN-1:0]  in_vec = '0;
    logic [SEL_W-1:0] sel = '0;
    logic             invert = 1'b0;
    logic [DLY_W-1:0] delay = '0;
    logic             arm = 1'b0;
    logic             step_done;
    logic             timing;

    always #2 clk = ~clk;

    qual_step_detector #(
        .N_IN     (N_IN),
        .SEL_W    (SEL_W),
        .DLY_W    (DLY_W),
        .TICK_DIV (DIV)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vec    (in_vec),
        .sel       (sel),
        .invert    (invert),
        .delay     (delay),
        .arm       (arm),
        .step_done (step_done),
        .timing    (timing)
    );

    int    cyc = 0;
    int    n_chk = 0;
    int    n_err = 0;
    int    exp_cyc[$];
    string exp_req[$];
    string cur_req = "R8";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int c, string req);
        exp_cyc.push_back(c);
        exp_req.push_back(req);
    endtask

    // monitor: every completion pulse must match the head of the scoreboard
    always @(negedge clk) begin : mon
        int    e;
        string r;
        if (rst_n && step_done) begin
            if (exp_cyc.size() == 0) begin
                check(1'b0, cur_req, "unexpected step_done at cycle", cyc, -1);
            end else begin
                e = exp_cyc.pop_front();
                r = exp_req.pop_front();
                check(cyc == e, r, "step_done cycle", cyc, e);
            end
        end
    end

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(string req);
        ticks(40);
        check(exp_cyc.size() == 0, req, "pending step_done count", exp_cyc.size(), 0);
        exp_cyc.delete();
        exp_req.delete();
    endtask

    // arm is raised at the current negedge (cycle c) and dropped one cycle later
    task automatic pulse_arm(output int c);
        c   = cyc;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired at cycle", cyc, 0);
        summary();
    end

    initial begin
        int c;
        int c2;
        ticks(3);
        check(step_done == 1'b0, "R1", "step_done after reset", step_done, 0);
        check(timing == 1'b0, "R1", "timing after reset", timing, 0);
        rst_n = 1'b1;
        ticks(3);
        check(timing == 1'b0, "R1", "timing idle after reset", timing, 0);

        // R5: watch bit 2 high, dwell 3 ticks
        sel = 3'd2; invert = 1'b0; delay = 19'd3; in_vec = '0;
        ticks(4);
        pulse_arm(c);
        check(timing == 1'b1, "R2", "timing after arm", timing, 1);
        ticks(3);
        c2 = cyc;
        in_vec[2] = 1'b1;
        push(c2 + 2 + 3 * DIV, "R5");
        drain("R5");
        check(timing == 1'b0, "R8", "timing after done", timing, 0);

        // R6: one-cycle drop during dwell restarts qualification
        in_vec = '0;
        ticks(4);
        pulse_arm(c);
        ticks(2);
        c2 = cyc;
        in_vec[2] = 1'b1;
        ticks(5);
        in_vec[2] = 1'b0;
        ticks(1);
        c2 = cyc;
        in_vec[2] = 1'b1;
        push(c2 + 2 + 3 * DIV, "R6");
        drain("R6");

        // R4: inverted polarity on bit 5, dwell 2
        sel = 3'd5; invert = 1'b1; delay = 19'd2; in_vec = '1;
        ticks(4);
        pulse_arm(c);
        ticks(3);
        check(timing == 1'b1, "R4", "timing while line high with invert", timing, 1);
        c2 = cyc;
        in_vec[5] = 1'b0;
        push(c2 + 2 + 2 * DIV, "R4");
        drain("R4");

        // R7: dwell 0, line rises after arm
        sel = 3'd0; invert = 1'b0; delay = '0; in_vec = '0;
        ticks(4);
        pulse_arm(c);
        ticks(2);
        c2 = cyc;
        in_vec[0] = 1'b1;
        push(c2 + 3, "R7");
        drain("R7");

        // R7: dwell 0, line already at target when armed
        pulse_arm(c);
        push(c + 2, "R7");
        drain("R7");

        // R9: re-arm from done with line already at target, dwell 2
        delay = 19'd2;
        pulse_arm(c);
        push(c + 1 + 2 * DIV, "R9");
        drain("R9");

        // R3: other bits toggle, watched bit 6 stays low
        sel = 3'd6; invert = 1'b0; delay = 19'd1; in_vec = '0;
        ticks(4);
        cur_req = "R3";
        pulse_arm(c);
        for (int i = 0; i < 30; i++) begin
            in_vec = (i % 2 == 0) ? 8'hBF : 8'h00;
            ticks(1);
        end
        in_vec = 8'hBF;
        ticks(20);
        check(timing == 1'b1, "R3", "still armed after foreign activity", timing, 1);
        c2 = cyc;
        in_vec[6] = 1'b1;
        push(c2 + 2 + DIV, "R3");
        drain("R3");

        // R8: no further pulse without a new arm
        cur_req = "R8";
        for (int i = 0; i < 10; i++) begin
            in_vec[6] = ~in_vec[6];
            ticks(8);
        end
        in_vec[6] = 1'b1;
        ticks(30);
        check(timing == 1'b0, "R8", "timing stays low after done", timing, 0);
        drain("R8");

        // R9: re-arm mid-dwell restarts from the second arm
        cur_req = "R9";
        sel = 3'd1; delay = 19'd3; in_vec = 8'h02;
        ticks(4);
        pulse_arm(c);
        ticks(5);
        pulse_arm(c2);
        push(c2 + 1 + 3 * DIV, "R9");
        drain("R9");

        summary();
    end

endmodule